// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block sits beside a DRAM command scheduler and makes sure that periodic refreshes happen without breaking DRAM timing. A free-running interval timer marks when each refresh falls due. When one falls due, the sequencer takes away the scheduler's permission to start accesses. It waits until the outstanding-access count reaches zero. It then closes every open bank with a precharge, observing the per-bank active-to-precharge minimum. It waits the precharge recovery time after the last precharge and issues one refresh strobe. Permission to access returns only after the refresh duration has passed.

The scheduler reports the activates and page closes it performs as one strobe per bank. From these the sequencer knows which banks hold an open row and how long each has been open. While permission is withdrawn, activate strobes are ignored. A counter of all-banks-closed cycles is kept alongside for power accounting. Cycles spent inside the refresh are never added to it.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the phase output is 0 (idle), grant is 1, no precharge or refresh strobe is active and the idle counter is 0.
- R2: The phase leaves idle for drain exactly T_REFI cycles after reset and again at every later multiple of T_REFI. The due time never shifts because an earlier refresh finished late.
- R3: Grant is 1 only in the idle phase and 0 in the drain, precharge and refresh phases.
- R4: The drain phase holds while the in-flight count is non-zero. It moves to the precharge phase at the clock edge at which it sees a count of zero.
- R5: In the precharge phase each open bank receives exactly one precharge strobe. The strobe comes no earlier than T_RAS cycles after that bank's activate strobe.
- R6: The refresh strobe is a single-cycle pulse issued exactly T_RP cycles after the last precharge strobe of the sequence.
- R7: If no bank is open when the precharge phase starts, the refresh strobe is issued in the first precharge-phase cycle and no precharge strobe appears.
- R8: The refresh phase lasts exactly T_RFC cycles, after which the phase returns to idle and grant is restored.
- R9: The idle counter increments once per cycle in which no bank is open and the phase is not refresh. It holds in every other cycle.
- R10: Activate strobes presented while grant is 0 are ignored: such a bank is not considered open and gets no precharge.
- R11: A page-close strobe from the scheduler marks that bank closed. It then gets no precharge at the next refresh.
- R12: The phase output encodes idle=0, drain=1, precharge=2, refresh=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing unit |
| rst | input | 1 | Synchronous active-high reset |
| act_stb | input | NUM_BANKS | Per-bank activate performed by the scheduler |
| close_stb | input | NUM_BANKS | Per-bank page close performed by the scheduler |
| inflight | input | INFL_W | Number of accesses still in progress |
| grant | output | 1 | Scheduler may start new accesses |
| pre_stb | output | NUM_BANKS | Per-bank precharge command strobe |
| ref_stb | output | 1 | Refresh command strobe |
| ref_phase | output | 2 | Current sequencer phase |
| idle_cycles | output | IDLE_W | Count of all-banks-closed cycles outside refresh |

## Verification
The bench opens two banks at different times, so that one has met its active-to-precharge minimum at the start of the precharge phase and the other has not. A design that ignored that minimum would precharge both in the same cycle, and a wrong recovery count would move the refresh strobe off its expected cycle. The first refresh is delayed by a long drain. This checks that the second refresh still falls due on the original grid, where a drifting timer would start it late. An activate during refresh and a scheduler-closed bank probe R10 and R11: a design that tracked either wrongly would emit an unexpected precharge. The idle counter is compared across refresh windows and open-bank windows, which catches a count that leaks refresh time.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_PRE   = 2'd2,
        RS_RUN   = 2'd3
    } rf_phase_e;

    typedef struct packed {
        logic open;
        logic ras_ok;
    } bank_stat_t;

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/dram_refresh_interval.sv
module dram_refresh_interval #(
    parameter int T_REFI = 7800
) (
    input  logic clk,
    input  logic rst,
    output logic due
);
    localparam int W = dram_refresh_pkg::cnt_width(T_REFI);

    logic [W-1:0] cnt;

    assign due = (cnt == W'(T_REFI - 1));

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (due) cnt <= '0;
        else          cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/dram_refresh_bank.sv
module dram_refresh_bank #(
    parameter int T_RAS = 35
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          act,
    input  logic                          close,
    output dram_refresh_pkg::bank_stat_t  stat
);
    localparam int W = dram_refresh_pkg::cnt_width(T_RAS);

    logic         open_q;
    logic [W-1:0] ras_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ras_q  <= '0;
        end else if (act) begin
            open_q <= 1'b1;
            ras_q  <= W'(T_RAS - 1);
        end else begin
            if (close)
                open_q <= 1'b0;
            if (ras_q != '0)
                ras_q <= ras_q - W'(1);
        end
    end

    assign stat.open   = open_q;
    assign stat.ras_ok = (ras_q == '0);
endmodule

// File: rtl/dram_refresh_downcnt.sv
module dram_refresh_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int NUM_BANKS = 8,
    parameter int INFL_W    = 6,
    parameter int IDLE_W    = 32,
    parameter int T_REFI    = 7800,
    parameter int T_RP      = 14,
    parameter int T_RFC     = 260,
    parameter int T_RAS     = 35
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] act_stb,
    input  logic [NUM_BANKS-1:0] close_stb,
    input  logic [INFL_W-1:0]    inflight,
    output logic                 grant,
    output logic [NUM_BANKS-1:0] pre_stb,
    output logic                 ref_stb,
    output logic [1:0]           ref_phase,
    output logic [IDLE_W-1:0]    idle_cycles
);
    import dram_refresh_pkg::*;

    localparam int RP_W  = cnt_width(T_RP);
    localparam int RFC_W = cnt_width(T_RFC);

    rf_phase_e              phase_q, phase_d;
    logic                   pend_q;
    logic                   due;
    bank_stat_t             stat [NUM_BANKS];
    logic [NUM_BANKS-1:0]   open_vec, ras_vec;
    logic                   any_open;
    logic                   rp_zero, rfc_zero;
    logic                   rp_load;
    logic [RP_W-1:0]        rp_val;

    dram_refresh_interval #(.T_REFI(T_REFI)) u_interval (
        .clk (clk),
        .rst (rst),
        .due (due)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dram_refresh_bank #(.T_RAS(T_RAS)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .act   (act_stb[b] & grant),
            .close (close_stb[b] | pre_stb[b]),
            .stat  (stat[b])
        );
        assign open_vec[b] = stat[b].open;
        assign ras_vec[b]  = stat[b].ras_ok;
    end

    assign any_open = |open_vec;
    assign grant    = (phase_q == RS_IDLE);
    assign pre_stb  = (phase_q == RS_PRE) ? (open_vec & ras_vec) : '0;
    assign ref_stb  = (phase_q == RS_PRE) && !any_open && rp_zero;

    // Recovery timer: cleared outside the precharge phase, reloaded by each precharge.
    assign rp_load = (phase_q != RS_PRE) || (|pre_stb);
    assign rp_val  = (|pre_stb) ? RP_W'(T_RP - 1) : '0;

    dram_refresh_downcnt #(.W(RP_W)) u_rp (
        .clk      (clk),
        .rst      (rst),
        .load     (rp_load),
        .load_val (rp_val),
        .zero     (rp_zero)
    );

    dram_refresh_downcnt #(.W(RFC_W)) u_rfc (
        .clk      (clk),
        .rst      (rst),
        .load     (ref_stb),
        .load_val (RFC_W'(T_RFC - 1)),
        .zero     (rfc_zero)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            RS_IDLE:  if (pend_q || due)     phase_d = RS_DRAIN;
            RS_DRAIN: if (inflight == '0)    phase_d = RS_PRE;
            RS_PRE:   if (ref_stb)           phase_d = RS_RUN;
            RS_RUN:   if (rfc_zero)          phase_d = RS_IDLE;
            default:                         phase_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= RS_IDLE;
            pend_q      <= 1'b0;
            idle_cycles <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == RS_IDLE && (pend_q || due))
                pend_q <= 1'b0;
            else if (due)
                pend_q <= 1'b1;
            if (phase_q != RS_RUN && !any_open)
                idle_cycles <= idle_cycles + IDLE_W'(1);
        end
    end

    assign ref_phase = phase_q;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
    parameter int NUM_BANKS = 8,
    parameter int INFL_W    = 6,
    parameter int IDLE_W    = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 grant,
    input logic [NUM_BANKS-1:0] pre_stb,
    input logic                 ref_stb,
    input logic [1:0]           ref_phase,
    input logic [INFL_W-1:0]    inflight,
    input logic [IDLE_W-1:0]    idle_cycles
);
    // R5: precharges only occur while access permission is withdrawn
    a_r5_pre_not_granted: assert property (@(posedge clk) disable iff (rst)
        grant |-> (pre_stb == '0));

    // R6: refresh strobe lasts one cycle
    a_r6_ref_single: assert property (@(posedge clk) disable iff (rst)
        ref_stb |=> !ref_stb);

    // R8: the refresh phase follows the strobe
    a_r8_run_after_ref: assert property (@(posedge clk) disable iff (rst)
        ref_stb |=> (ref_phase == 2'd3));

    // R4: drain holds while accesses remain
    a_r4_drain_hold: assert property (@(posedge clk) disable iff (rst)
        (ref_phase == 2'd1 && inflight != '0) |=> (ref_phase == 2'd1));

    // R9: refresh cycles never count as idle
    a_r9_run_frozen: assert property (@(posedge clk) disable iff (rst)
        (ref_phase == 2'd3) |=> $stable(idle_cycles));

    // R2: idle only ever moves on to drain
    a_r2_idle_exit: assert property (@(posedge clk) disable iff (rst)
        (ref_phase == 2'd0) |=> (ref_phase == 2'd0 || ref_phase == 2'd1));
endmodule

bind dram_refresh_ctrl dram_refresh_chk #(
    .NUM_BANKS (NUM_BANKS),
    .INFL_W    (INFL_W),
    .IDLE_W    (IDLE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .grant       (grant),
    .pre_stb     (pre_stb),
    .ref_stb     (ref_stb),
    .ref_phase   (ref_phase),
    .inflight    (inflight),
    .idle_cycles (idle_cycles)
);

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] act_stb = '0;
    logic [NB-1:0] close_stb = '0;
    logic [3:0]    inflight = '0;
    logic          grant;
    logic [NB-1:0] pre_stb;
    logic          ref_stb;
    logic [1:0]    ref_phase;
    logic [31:0]   idle_cycles;

    always #10 clk = ~clk;

    dram_refresh_ctrl #(
        .NUM_BANKS(NB), .INFL_W(4), .IDLE_W(32),
        .T_REFI(400), .T_RP(4), .T_RFC(20), .T_RAS(6)
    ) uut (
        .clk(clk), .rst(rst), .act_stb(act_stb), .close_stb(close_stb),
        .inflight(inflight), .grant(grant), .pre_stb(pre_stb),
        .ref_stb(ref_stb), .ref_phase(ref_phase), .idle_cycles(idle_cycles)
    );

    typedef struct {
        int            cyc;
        bit            is_ref;
        logic [NB-1:0] mask;
    } evt_t;

    evt_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    int   idle_snap [int];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_evt(input int cyc, input bit is_ref, input logic [NB-1:0] mask);
        evt_t e;
        e.cyc = cyc; e.is_ref = is_ref; e.mask = mask;
        q.push_back(e);
    endtask

    // Monitor: every strobe seen must match the head of the expected queue
    task automatic monitor(input int k);
        evt_t e;
        if (pre_stb != '0 || ref_stb) begin
            if (q.size() == 0) begin
                check(1'b0, "R5/R6/R10/R11 unexpected strobe", k, -1);
            end else begin
                e = q.pop_front();
                check(e.cyc == k, "R5/R6/R7 strobe cycle", k, e.cyc);
                check(ref_stb == e.is_ref, "R6/R7 refresh strobe", int'(ref_stb), int'(e.is_ref));
                check(pre_stb == e.mask, "R5 precharge mask", int'(pre_stb), int'(e.mask));
            end
        end
    endtask

    task automatic drive(input int k);
        inflight  = (k >= 390 && k < 410) ? 4'd3 : 4'd0;
        act_stb   = '0;
        close_stb = '0;
        if (k == 415) act_stb = 4'b0010;   // R10: during refresh, ignored
        if (k == 700) act_stb = 4'b1000;
        if (k == 720) close_stb = 4'b1000; // R11
        if (k == 790) act_stb = 4'b0100;
        if (k == 796) act_stb = 4'b0001;
    endtask

    task automatic spot(input int k);
        if (k == 399) check(ref_phase == 2'd0, "R2 still idle before due", ref_phase, 0);
        if (k == 400) check(ref_phase == 2'd1, "R2/R12 drain at T_REFI", ref_phase, 1);
        if (k == 405) check(grant == 1'b0, "R3 grant low in drain", grant, 0);
        if (k == 410) check(ref_phase == 2'd1, "R4 drain holds with inflight", ref_phase, 1);
        if (k == 411) begin
            check(ref_phase == 2'd2, "R4/R12 precharge phase", ref_phase, 2);
            check(grant == 1'b0, "R3 grant low in precharge", grant, 0);
            check(idle_cycles == 32'd411, "R9 idle count before refresh", idle_cycles, 411);
        end
        if (k == 412) check(ref_phase == 2'd3, "R12 refresh phase", ref_phase, 3);
        if (k == 420) check(grant == 1'b0, "R3 grant low in refresh", grant, 0);
        if (k == 431) check(ref_phase == 2'd3, "R8 refresh lasts T_RFC", ref_phase, 3);
        if (k == 432) begin
            check(ref_phase == 2'd0, "R8 back to idle", ref_phase, 0);
            check(grant == 1'b1, "R3/R8 grant restored", grant, 1);
            check(idle_cycles == 32'd412, "R9 refresh not counted", idle_cycles, 412);
        end
        if (k == 701 || k == 721 || k == 722 || k == 803 || k == 807 || k == 827)
            idle_snap[k] = int'(idle_cycles);
        if (k == 721) check(idle_snap[721] == idle_snap[701], "R9 holds with bank open",
                            idle_snap[721], idle_snap[701]);
        if (k == 722) check(idle_snap[722] == idle_snap[721] + 1, "R11 closed bank resumes idle",
                            idle_snap[722], idle_snap[721] + 1);
        if (k == 799) check(ref_phase == 2'd0, "R2 idle before second due", ref_phase, 0);
        if (k == 800) check(ref_phase == 2'd1, "R2 no drift second due", ref_phase, 1);
        if (k == 807) check(idle_snap[807] == idle_snap[803] + 4, "R9 counts closed precharge cycles",
                            idle_snap[807], idle_snap[803] + 4);
        if (k == 826) check(ref_phase == 2'd3, "R8 second refresh length", ref_phase, 3);
        if (k == 827) check(idle_snap[827] == idle_snap[807], "R9 second refresh not counted",
                            idle_snap[827], idle_snap[807]);
        if (k == 1200) check(ref_phase == 2'd1, "R2 third due", ref_phase, 1);
        if (k == 1222) check(ref_phase == 2'd0, "R8 third refresh done", ref_phase, 0);
    endtask

    initial begin
        // Expected strobe sequence
        push_evt(411, 1'b1, 4'b0000);   // R7: nothing open
        push_evt(801, 1'b0, 4'b0100);   // R5: bank 2 met T_RAS
        push_evt(802, 1'b0, 4'b0001);   // R5: bank 0 one cycle later
        push_evt(806, 1'b1, 4'b0000);   // R6: T_RP after last precharge
        push_evt(1201, 1'b1, 4'b0000);  // R7
        repeat (3) @(posedge clk);
        check(ref_phase == 2'd0 && grant && pre_stb == '0 && !ref_stb,
              "R1 outputs during reset", ref_phase, 0);
        @(negedge clk);
        rst = 1'b0;
        check(ref_phase == 2'd0, "R1 idle phase after reset", ref_phase, 0);
        check(grant == 1'b1, "R1 grant after reset", grant, 1);
        check(idle_cycles == 32'd0, "R1 idle counter after reset", idle_cycles, 0);
        check(pre_stb == '0 && !ref_stb, "R1 no strobes after reset", int'(pre_stb), 0);
        drive(0);
        for (int k = 1; k <= 1240; k++) begin
            @(negedge clk);
            monitor(k);
            spot(k);
            drive(k);
        end
        check(q.size() == 0, "R5/R6/R7 all expected strobes seen", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule